// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block sits between a 16-bit-data processor bus with a 24-bit byte address and the targets behind it. It sorts every access into one of the following: a pair of 8-bit peripheral adapters, a custom register file, an expansion configuration window, chip RAM, other mapped memory, or open bus. For each access it drives the target selects and steers the byte lanes of the 8-bit peripherals. It raises a slow-peripheral indication for the peripheral window and for interrupt acknowledge, merges read data back onto the 16-bit bus, and returns a ready signal to the processor.

The address space is split into 64 regions by the top six address bits. A parameter mask marks each region either as direct memory or as special-decode space. Direct regions below 0x200000 are chip RAM. That RAM is shared with other bus masters, so the access waits until an external arbiter grants the processor's slot. The two peripherals share one window. Each one is enabled by its own active-low address bit and owns one data byte, so a single word access can reach both of them.

Top module: `bus_addr_decoder`

## Requirements
- R1: An access with address bits 23:21 equal to 3'b101 and no interrupt acknowledge asserts `vpa` in the same cycle. If that address lies in a special-decode region, it also targets the peripheral window.
- R2: In the peripheral window, `perASel` is high exactly when address bit 12 is 0, and `perBSel` is high exactly when address bit 13 is 0. Both may be high together.
- R3: `perRegIdx` equals address bits 11:8 during a peripheral access.
- R4: A peripheral read returns `perBRdData` on bits 15:8 when B is selected and 8'hFF otherwise. It returns `perARdData` on bits 7:0 when A is selected and 8'hFF otherwise.
- R5: A peripheral write pulses `perAWr` only with `lowerByteEn` and A selected, and `perBWr` only with `upperByteEn` and B selected. `perAWrData` carries write bits 7:0 and `perBWrData` carries write bits 15:8. Reads never raise either write strobe.
- R6: Special-space addresses from 0xDFF000 through 0xDFF1BE inclusive assert `custSel`, and `busReady` follows `custReady`. Address 0xDFF1C0 does not.
- R7: Special-space addresses from 0xE80000 through 0xE8FFFF assert `expSel`, and `busReady` follows `expReady`. Address 0xE90000 does not.
- R8: Any other special-space address is open bus: no select or write strobe is raised, `busReady` is 1, and reads return 0xFFFF.
- R9: With the default mask, the regions for addresses 0x000000–0x9FFFFF and 0xF80000–0xFFFFFF are direct. A direct address at or above 0x200000 asserts `memSel`, returns `memRdData`, and `busReady` follows `memReady`.
- R10: A direct address below 0x200000 raises `slotReq` and holds `busReady` and `chipSel` low. Both go high from the cycle after `slotGrant` is sampled high at a clock edge, and stay high while `addrStrobe` is held. Read data is then `chipRdData`.
- R11: With `intAck` high during `addrStrobe`, `vpa` is 1, `busReady` is 1, and no select, write strobe or `slotReq` is raised.
- R12: With `addrStrobe` low, every select, write strobe and `slotReq` is low and `busReady` is 1. A chip access that follows must wait for a fresh grant.
- R13: `tgtWrite` is high for a write to the custom, expansion, chip or memory target, and low for reads and for open bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrStrobe | input | 1 | Address valid for the current access |
| intAck | input | 1 | Interrupt-acknowledge cycle |
| busRead | input | 1 | 1 = read, 0 = write |
| upperByteEn | input | 1 | Data bits 15:8 take part |
| lowerByteEn | input | 1 | Data bits 7:0 take part |
| busAddr | input | 24 | Byte address |
| wrData | input | 16 | Write data from processor |
| rdData | output | 16 | Read data to processor |
| busReady | output | 1 | Access may complete |
| vpa | output | 1 | Slow-peripheral / autovector indication |
| tgtWrite | output | 1 | Write qualifier for word targets |
| perASel | output | 1 | Peripheral A select |
| perBSel | output | 1 | Peripheral B select |
| perAWr | output | 1 | Peripheral A write strobe |
| perBWr | output | 1 | Peripheral B write strobe |
| perRegIdx | output | 4 | Peripheral register index |
| perAWrData | output | 8 | Write byte to peripheral A |
| perBWrData | output | 8 | Write byte to peripheral B |
| perARdData | input | 8 | Read byte from peripheral A |
| perBRdData | input | 8 | Read byte from peripheral B |
| custSel | output | 1 | Custom register select |
| custReady | input | 1 | Custom register access done |
| custRdData | input | 16 | Custom register read data |
| expSel | output | 1 | Expansion window select |
| expReady | input | 1 | Expansion access done |
| expRdData | input | 16 | Expansion read data |
| memSel | output | 1 | Mapped memory select |
| memReady | input | 1 | Mapped memory access done |
| memRdData | input | 16 | Mapped memory read data |
| slotReq | output | 1 | Request for the shared chip RAM slot |
| slotGrant | input | 1 | Processor slot has arrived |
| chipSel | output | 1 | Chip RAM select |
| chipRdData | input | 16 | Chip RAM read data |

## Verification
Nearly all of the decode is combinational, so a wrong comparison or lane choice appears at the select, lane and read-data ports in the same cycle the address is applied. The only held state is the slot-wait machine. If it is stuck or grants early, `busReady` and `chipSel` rise before a grant or never rise. If it fails to clear, a following chip access completes without a fresh grant. Either fault shows within one or two cycles of the grant edge or of the strobe dropping. The random mix targets each window's edges, so off-by-one limits show on the first vector that lands on a boundary.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PERIPH,
    TGT_CUST,
    TGT_EXP,
    TGT_CHIP,
    TGT_MEM,
    TGT_OPEN
  } target_e;

  typedef struct packed {
    logic slotReq;
    logic chipGo;
  } ctl_strobes_t;

endpackage

// File: rtl/bus_dec_datapath.sv
module bus_dec_datapath
  import bus_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int REGION_BITS = 6,
  parameter logic [(1<<REGION_BITS)-1:0] REGION_DIRECT = 64'hC000_00FF_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] CHIP_LIMIT = 24'h20_0000,
  parameter logic [2:0] PERIPH_TAG = 3'b101,
  parameter int SEL_A_BIT = 12,
  parameter int SEL_B_BIT = 13,
  parameter int IDX_LSB = 8,
  parameter int IDX_W = 4,
  parameter logic [ADDR_W-1:0] CUST_LO = 24'hDF_F000,
  parameter logic [ADDR_W-1:0] CUST_HI = 24'hDF_F1BE,
  parameter logic [ADDR_W-1:0] EXP_LO = 24'hE8_0000,
  parameter logic [ADDR_W-1:0] EXP_END = 24'hE9_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrStrobe,
  input  logic               intAck,
  input  logic               busRead,
  input  logic               upperByteEn,
  input  logic               lowerByteEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  ctl_strobes_t       ctl,
  output logic               isChip,
  output logic [DATA_W-1:0]  rdData,
  output logic               busReady,
  output logic               vpa,
  output logic               tgtWrite,
  output logic               perASel,
  output logic               perBSel,
  output logic               perAWr,
  output logic               perBWr,
  output logic [IDX_W-1:0]   perRegIdx,
  output logic [7:0]         perAWrData,
  output logic [7:0]         perBWrData,
  input  logic [7:0]         perARdData,
  input  logic [7:0]         perBRdData,
  output logic               custSel,
  input  logic               custReady,
  input  logic [DATA_W-1:0]  custRdData,
  output logic               expSel,
  input  logic               expReady,
  input  logic [DATA_W-1:0]  expRdData,
  output logic               memSel,
  input  logic               memReady,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               chipSel,
  input  logic [DATA_W-1:0]  chipRdData
);

  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] OPEN_VALUE = '1;

  target_e target;
  logic inWindow;
  logic direct;
  logic active;
  logic [REGION_BITS-1:0] regionIdx;
  logic [LANES-1:0] laneSel;
  logic [LANES-1:0] laneStrobe;
  logic [7:0] laneRd [LANES];
  logic [DATA_W-1:0] periphWord;

  assign regionIdx = busAddr[ADDR_W-1 -: REGION_BITS];
  assign direct    = REGION_DIRECT[regionIdx];
  assign inWindow  = (busAddr[ADDR_W-1 -: 3] == PERIPH_TAG);
  assign active    = addrStrobe && !intAck;

  always_comb begin
    if (!active)                                  target = TGT_NONE;
    else if (direct)                              target = (busAddr < CHIP_LIMIT) ? TGT_CHIP : TGT_MEM;
    else if (inWindow)                            target = TGT_PERIPH;
    else if (busAddr >= CUST_LO && busAddr <= CUST_HI) target = TGT_CUST;
    else if (busAddr >= EXP_LO && busAddr < EXP_END)   target = TGT_EXP;
    else                                          target = TGT_OPEN;
  end

  assign isChip = (target == TGT_CHIP);

  // Lane 0 belongs to peripheral A, lane 1 to peripheral B.
  assign laneSel[0]    = (target == TGT_PERIPH) && !busAddr[SEL_A_BIT];
  assign laneSel[1]    = (target == TGT_PERIPH) && !busAddr[SEL_B_BIT];
  assign laneStrobe[0] = lowerByteEn;
  assign laneStrobe[1] = upperByteEn;
  assign laneRd[0]     = perARdData;
  assign laneRd[1]     = perBRdData;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign periphWord[g*8 +: 8] = laneSel[g] ? laneRd[g] : 8'hFF;
    end
  endgenerate

  assign perASel    = laneSel[0];
  assign perBSel    = laneSel[1];
  assign perAWr     = laneSel[0] && !busRead && laneStrobe[0];
  assign perBWr     = laneSel[1] && !busRead && laneStrobe[1];
  assign perRegIdx  = busAddr[IDX_LSB +: IDX_W];
  assign perAWrData = wrData[7:0];
  assign perBWrData = wrData[15:8];

  assign custSel = (target == TGT_CUST);
  assign expSel  = (target == TGT_EXP);
  assign memSel  = (target == TGT_MEM);
  assign chipSel = isChip && ctl.chipGo;

  assign tgtWrite = !busRead && (custSel || expSel || memSel || chipSel);
  assign vpa      = addrStrobe && (intAck || inWindow);

  always_comb begin
    case (target)
      TGT_CUST: begin busReady = custReady;  rdData = custRdData; end
      TGT_EXP:  begin busReady = expReady;   rdData = expRdData;  end
      TGT_MEM:  begin busReady = memReady;   rdData = memRdData;  end
      TGT_CHIP: begin busReady = ctl.chipGo; rdData = chipRdData; end
      TGT_PERIPH: begin busReady = 1'b1;     rdData = periphWord; end
      default:  begin busReady = 1'b1;       rdData = OPEN_VALUE; end
    endcase
  end

  // R12: no strobe means no target and a free bus.
  p_idle_free_r12: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobe |-> (busReady && !perASel && !perBSel && !custSel && !expSel && !memSel && !chipSel));

  // R8: at most one word target or the peripheral window at a time.
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({perASel || perBSel, custSel, expSel, memSel, chipSel}));

  // R11: interrupt acknowledge touches no target.
  p_intack_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && intAck) |-> (vpa && busReady && !perASel && !perBSel && !custSel && !expSel && !memSel && !chipSel));

  // R4: an unselected peripheral lane reads as all ones.
  p_lane_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (perBSel && !perASel) |-> (rdData[7:0] == 8'hFF));

  // R5: peripheral write strobes never appear on a read.
  p_no_read_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> (!perAWr && !perBWr && !tgtWrite));

endmodule

// File: rtl/bus_dec_control.sv
module bus_dec_control
  import bus_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrStrobe,
  input  logic         isChip,
  input  logic         slotGrant,
  output ctl_strobes_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_GRANTED} state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (!addrStrobe || !isChip) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT: stateNext = slotGrant ? ST_GRANTED : ST_WAIT;
        default:          stateNext = ST_GRANTED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctl.chipGo  = (state == ST_GRANTED) && addrStrobe && isChip;
  assign ctl.slotReq = addrStrobe && isChip && (state != ST_GRANTED);

  // R10: the granted state is entered only after a sampled grant.
  p_grant_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRANTED && $past(state) != ST_GRANTED) |-> $past(slotGrant));

  // R12: dropping the strobe forgets any earlier grant.
  p_drop_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobe |=> (state == ST_IDLE));

  // R10: request and go are never raised together.
  p_req_go_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.slotReq && ctl.chipGo));

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import bus_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int REGION_BITS = 6,
  parameter logic [(1<<REGION_BITS)-1:0] REGION_DIRECT = 64'hC000_00FF_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] CHIP_LIMIT = 24'h20_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic              intAck,
  input  logic              busRead,
  input  logic              upperByteEn,
  input  logic              lowerByteEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busReady,
  output logic              vpa,
  output logic              tgtWrite,
  output logic              perASel,
  output logic              perBSel,
  output logic              perAWr,
  output logic              perBWr,
  output logic [3:0]        perRegIdx,
  output logic [7:0]        perAWrData,
  output logic [7:0]        perBWrData,
  input  logic [7:0]        perARdData,
  input  logic [7:0]        perBRdData,
  output logic              custSel,
  input  logic              custReady,
  input  logic [DATA_W-1:0] custRdData,
  output logic              expSel,
  input  logic              expReady,
  input  logic [DATA_W-1:0] expRdData,
  output logic              memSel,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdData,
  output logic              slotReq,
  input  logic              slotGrant,
  output logic              chipSel,
  input  logic [DATA_W-1:0] chipRdData
);

  ctl_strobes_t ctl;
  logic isChip;

  bus_dec_control uCtl (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe),
    .isChip(isChip), .slotGrant(slotGrant), .ctl(ctl)
  );

  bus_dec_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BITS(REGION_BITS),
    .REGION_DIRECT(REGION_DIRECT), .CHIP_LIMIT(CHIP_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .intAck(intAck),
    .busRead(busRead), .upperByteEn(upperByteEn), .lowerByteEn(lowerByteEn),
    .busAddr(busAddr), .wrData(wrData), .ctl(ctl), .isChip(isChip),
    .rdData(rdData), .busReady(busReady), .vpa(vpa), .tgtWrite(tgtWrite),
    .perASel(perASel), .perBSel(perBSel), .perAWr(perAWr), .perBWr(perBWr),
    .perRegIdx(perRegIdx), .perAWrData(perAWrData), .perBWrData(perBWrData),
    .perARdData(perARdData), .perBRdData(perBRdData),
    .custSel(custSel), .custReady(custReady), .custRdData(custRdData),
    .expSel(expSel), .expReady(expReady), .expRdData(expRdData),
    .memSel(memSel), .memReady(memReady), .memRdData(memRdData),
    .chipSel(chipSel), .chipRdData(chipRdData)
  );

  assign slotReq = ctl.slotReq;

endmodule

// File: tb/sim_bus_addr_decoder.sv
module sim_bus_addr_decoder;

  localparam logic [63:0] DIRECT_MAP = 64'hC000_00FF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrStrobe = 0, intAck = 0, busRead = 1, upperByteEn = 1, lowerByteEn = 1;
  logic [23:0] busAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic busReady, vpa, tgtWrite, perASel, perBSel, perAWr, perBWr;
  logic [3:0] perRegIdx;
  logic [7:0] perAWrData, perBWrData;
  logic [7:0] perARdData = 8'h11, perBRdData = 8'h22;
  logic custSel, expSel, memSel, slotReq, chipSel;
  logic custReady = 1, expReady = 1, memReady = 1, slotGrant = 0;
  logic [15:0] custRdData = 16'h3333, expRdData = 16'h4444, memRdData = 16'h5555, chipRdData = 16'h6666;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_addr_decoder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s addr=%06h actual=%0h expected=%0h", req, busAddr, act, exp);
    end
  endtask

  // 0 none,1 periph,2 cust,3 exp,4 chip,5 mem,6 open
  function automatic int expTarget(input logic [23:0] a, input logic ia, input logic as);
    if (!as || ia) return 0;
    if (DIRECT_MAP[a[23:18]]) return (a < 24'h200000) ? 4 : 5;
    if (a[23:21] == 3'b101) return 1;
    if (a >= 24'hDFF000 && a <= 24'hDFF1BE) return 2;
    if (a >= 24'hE80000 && a < 24'hE90000) return 3;
    return 6;
  endfunction

  task automatic checkComb(input bit granted);
    int t;
    logic sa, sb;
    logic [15:0] er;
    logic er_rdy;
    t  = expTarget(busAddr, intAck, addrStrobe);
    sa = (t == 1) && !busAddr[12];
    sb = (t == 1) && !busAddr[13];
    chk("R1 vpa", vpa, addrStrobe && (intAck || busAddr[23:21] == 3'b101));
    chk("R2 sel", {perBSel, perASel}, {sb, sa});
    if (t == 1) chk("R3 idx", perRegIdx, busAddr[11:8]);
    chk("R5 wr", {perBWr, perAWr}, {sb && !busRead && upperByteEn, sa && !busRead && lowerByteEn});
    chk("R5 lanes", {perBWrData, perAWrData}, wrData);
    chk("R6 cust", custSel, t == 2);
    chk("R7 exp", expSel, t == 3);
    chk("R9 mem", memSel, t == 5);
    chk("R10 chip", {chipSel, slotReq}, {t == 4 && granted, t == 4 && !granted});
    chk("R13 wr", tgtWrite, !busRead && (t == 2 || t == 3 || t == 5 || (t == 4 && granted)));
    case (t)
      1: begin er = {sb ? perBRdData : 8'hFF, sa ? perARdData : 8'hFF}; er_rdy = 1; end
      2: begin er = custRdData; er_rdy = custReady; end
      3: begin er = expRdData;  er_rdy = expReady;  end
      4: begin er = chipRdData; er_rdy = granted;   end
      5: begin er = memRdData;  er_rdy = memReady;  end
      default: begin er = 16'hFFFF; er_rdy = 1; end
    endcase
    chk(t == 0 ? "R12 ready" : (t == 6 ? "R8 ready" : "R4 ready"), busReady, er_rdy);
    if (busRead) chk(t == 6 ? "R8 rd" : "R4 rd", rdData, er);
  endtask

  task automatic access(input logic [23:0] a, input logic rd, input logic ub, input logic lb, input logic ia);
    int t;
    @(negedge clk);
    addrStrobe = 1; busAddr = a; busRead = rd; upperByteEn = ub; lowerByteEn = lb; intAck = ia;
    wrData = 16'($urandom); perARdData = 8'($urandom); perBRdData = 8'($urandom);
    custRdData = 16'($urandom); expRdData = 16'($urandom); memRdData = 16'($urandom);
    chipRdData = 16'($urandom);
    custReady = 1'($urandom); expReady = 1'($urandom); memReady = 1'($urandom);
    #1 checkComb(0);
    t = expTarget(a, ia, 1'b1);
    if (t == 4) begin
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk); #1 checkComb(0);
      end
      @(negedge clk) slotGrant = 1;
      @(negedge clk) slotGrant = 0;
      #1 checkComb(1);
      @(negedge clk); #1 checkComb(1);
    end
    @(negedge clk) addrStrobe = 0; intAck = 0;
    #1 checkComb(0);
  endtask

  function automatic logic [23:0] pickAddr();
    case ($urandom_range(0, 7))
      0: return {3'b101, 21'($urandom)};
      1: return 24'hDFF000 + 24'($urandom_range(0, 24'h1C2));
      2: return 24'hE80000 + 24'($urandom_range(0, 24'h10002)) - 24'd1;
      3: return 24'($urandom_range(0, 24'h1FFFFF));
      4: return 24'($urandom_range(24'h200000, 24'h9FFFFF));
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 chk("R12 reset", {busReady, perASel, perBSel, custSel, expSel, memSel, chipSel, slotReq}, 8'b1000_0000);
    rstN = 1;
    // directed corners
    access(24'hBFE001, 1, 1, 1, 0);  // A only (R2, R4)
    access(24'hBFD100, 1, 1, 1, 0);  // B only (R2, R4)
    access(24'hBFC300, 0, 1, 0, 0);  // both, only upper strobe (R5)
    access(24'hBFC300, 0, 0, 1, 0);  // both, only lower strobe (R5)
    access(24'hBFF000, 1, 1, 1, 0);  // neither: all ones (R4)
    access(24'hDFF1BE, 1, 1, 1, 0);  // R6 upper edge
    access(24'hDFF1C0, 1, 1, 1, 0);  // R6 just outside: open (R8)
    access(24'hDFEFFE, 0, 1, 1, 0);  // R8 write ignored
    access(24'hE8FFFE, 1, 1, 1, 0);  // R7 upper edge
    access(24'hE90000, 0, 1, 1, 0);  // R7 just outside
    access(24'h1FFFFE, 1, 1, 1, 0);  // R10 last chip word
    access(24'h200000, 0, 1, 1, 0);  // R9 first memory word
    access(24'hFC0000, 1, 1, 1, 0);  // R9 direct upper region
    access(24'h000100, 1, 1, 1, 1);  // R11 intack over chip address
    access(24'h000100, 0, 1, 1, 0);  // R10 again, fresh grant (R12)
    for (int i = 0; i < 600; i++)
      access(pickAddr(), 1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule